// File: doc/BRIEF.md
# Descriptor-Chain DMA Engine

This block is a bus-mastering copy engine that software steers through a small 32-bit register port. Software places a chain of three-word descriptors in host memory, writes the chain's start address into one of two pointer registers (one per direction), sets the direction's enable bit, and writes a start code to the command register. The engine reads each descriptor over the host memory port. It then copies the described number of bytes one 32-bit word at a time between the host memory port and the local memory port, and repeats for the next descriptor. Descriptors sit back to back in host memory, 12 bytes apart. A chain ends after the descriptor whose length word has bit 31 set. The engine serves one direction at a time. Status shows busy and error bits, and a one-cycle done strobe marks a completed chain.

The sequencer has five states. IDLE waits for an accepted start (IDLE to FETCH). FETCH reads the three descriptor words and moves to CHECK after the third. CHECK validates the length and moves to MOVE_RD, or returns to IDLE on an error or a pending abort. MOVE_RD reads one source word and moves to MOVE_WR. MOVE_WR writes that word to the destination. From MOVE_WR the engine goes back to MOVE_RD while bytes remain, to FETCH after a non-final descriptor, or to IDLE after the final word or on a pending abort. Every fetched descriptor word is also kept in a readable register set.

Top module: `ll_dma_engine`

## Requirements
- R1: After reset, status (offset 0x04), both list pointers (0x08 read, 0x0C write) and the enable register (0x10) read 0, no memory request is raised, and both done strobes are low.
- R2: A write to offset 0x00 of value 1 starts a read-direction chain, and a value of 2 starts a write-direction chain. Values 0 and 4 abort. Any other value is ignored. The busy bit of the started direction (status bit 0 read, bit 1 write) reads 1 in the cycle after the command write.
- R3: A start is ignored when its direction's enable bit (bit 0 read, bit 1 write, of offset 0x10) is 0, or when the engine is already busy in either direction.
- R4: Descriptors are fetched over the host port from consecutive 12-byte entries starting at the direction's list pointer. A write-direction entry holds local address, host address, length. A read-direction entry holds host address, local address, length. Length bits 30:0 are the byte count, and bit 31 marks the final entry.
- R5: A read-direction chain copies host memory to local memory, and a write-direction chain copies local memory to host memory. Both copy word by word, with both addresses stepping by 4.
- R6: Fetched write-direction descriptor k (k = 0..7) reads back at offsets 0x80+12k, +4, +8 in memory order. The most recent read-direction descriptor reads back at 0xE0, 0xE4, 0xE8.
- R7: The done strobe of the active direction is high for exactly one cycle. It rises in the same cycle that busy clears, after the last word of the final descriptor is accepted.
- R8: A descriptor whose byte count is 0 or not a multiple of 4 sets status bit 4 (link-list error) and the direction's error bit (bit 2 read, bit 3 write). It then ends the chain with no word of that descriptor moved and no done strobe.
- R9: If the eighth descriptor of a chain lacks the final flag, the engine raises the R8 error bits and moves none of that descriptor's words.
- R10: An abort takes effect at the next word boundary: an outstanding word completes and no further word starts. Busy clears, the error bits keep their values, and no done strobe fires.
- R11: Writing 1 to status bit 2, 3 or 4 clears that bit. Writing 0 leaves it unchanged.
- R12: On each memory port a request holds its address, write flag and write data unchanged until the port acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| hst_req | output | 1 | Host memory request |
| hst_we | output | 1 | Host request is a write |
| hst_addr | output | 32 | Host byte address |
| hst_wdata | output | 32 | Host write data |
| hst_ack | input | 1 | Host request accepted (read data valid with it) |
| hst_rdata | input | 32 | Host read data |
| loc_req | output | 1 | Local memory request |
| loc_we | output | 1 | Local request is a write |
| loc_addr | output | 32 | Local byte address |
| loc_wdata | output | 32 | Local write data |
| loc_ack | input | 1 | Local request accepted (read data valid with it) |
| loc_rdata | input | 32 | Local read data |
| rd_done | output | 1 | Read-direction chain complete strobe |
| wr_done | output | 1 | Write-direction chain complete strobe |

## Verification
A command write is sampled at one rising edge, and the busy bit, now a function of the new state, is due at the falling edge right after it. The bench therefore reads status at that falling edge, with no extra wait. Error bits, the cleared busy bit and the done strobe all come from the edge at which the sequencer returns to IDLE, so they are due together. The bench polls status at each falling edge and, at the first one where busy reads 0, checks the done strobe in that same sample. The memory models acknowledge at falling edges after a programmable number of wait cycles and record any change of address during a wait. This makes both the handshake rule and the word-boundary abort visible as counts at the ports.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_MOVE_RD,
        ST_MOVE_WR
    } walk_state_t;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dma_dir_t;

    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_RDPTR = 8'h08;
    localparam logic [7:0] OFS_WRPTR = 8'h0C;
    localparam logic [7:0] OFS_EN    = 8'h10;
    localparam logic [7:0] OFS_WSET  = 8'h80;
    localparam logic [7:0] OFS_RSET  = 8'hE0;

    localparam logic [31:0] CMD_CANCEL = 32'd0;
    localparam logic [31:0] CMD_RD     = 32'd1;
    localparam logic [31:0] CMD_WR     = 32'd2;
    localparam logic [31:0] CMD_STOP   = 32'd4;

    localparam int DESC_WORDS = 3;

endpackage

// File: rtl/lldma_csr.sv
module lldma_csr
    import lldma_pkg::*;
#(
    parameter int MAX_DESC = 8,
    localparam int SLOT_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy_rd,
    input  logic              busy_wr,
    input  logic              err_set,
    input  dma_dir_t          err_dir,
    input  logic              desc_we,
    input  dma_dir_t          desc_dir,
    input  logic [SLOT_W-1:0] desc_slot,
    input  logic [1:0]        desc_word,
    input  logic [31:0]       desc_data,
    output logic              start_rd,
    output logic              start_wr,
    output logic              abort_cmd,
    output logic [31:0]       rd_list_ptr,
    output logic [31:0]       wr_list_ptr
);

    logic [31:0] rd_ptr_q, wr_ptr_q;
    logic [1:0]  en_q;
    logic        err_rd_q, err_wr_q, err_lnk_q;
    logic [31:0] wset_q [MAX_DESC][DESC_WORDS];
    logic [31:0] rset_q [DESC_WORDS];
    logic        cmd_hit, stat_hit;

    assign cmd_hit  = reg_we && (reg_addr == OFS_CMD);
    assign stat_hit = reg_we && (reg_addr == OFS_STAT);

    // command decode; a direction must be enabled to start
    assign start_rd    = cmd_hit && (reg_wdata == CMD_RD) && en_q[0];
    assign start_wr    = cmd_hit && (reg_wdata == CMD_WR) && en_q[1];
    assign abort_cmd   = cmd_hit && ((reg_wdata == CMD_CANCEL) || (reg_wdata == CMD_STOP));
    assign rd_list_ptr = rd_ptr_q;
    assign wr_list_ptr = wr_ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q  <= '0;
            wr_ptr_q  <= '0;
            en_q      <= '0;
            err_rd_q  <= 1'b0;
            err_wr_q  <= 1'b0;
            err_lnk_q <= 1'b0;
        end else begin
            if (reg_we && reg_addr == OFS_RDPTR) rd_ptr_q <= reg_wdata;
            if (reg_we && reg_addr == OFS_WRPTR) wr_ptr_q <= reg_wdata;
            if (reg_we && reg_addr == OFS_EN)    en_q     <= reg_wdata[1:0];
            // set wins over a simultaneous write-one-to-clear
            err_rd_q  <= (err_rd_q  & ~(stat_hit & reg_wdata[2])) | (err_set & (err_dir == DIR_RD));
            err_wr_q  <= (err_wr_q  & ~(stat_hit & reg_wdata[3])) | (err_set & (err_dir == DIR_WR));
            err_lnk_q <= (err_lnk_q & ~(stat_hit & reg_wdata[4])) | err_set;
        end
    end

    // descriptor mirror sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < MAX_DESC; s++) begin
                for (int w = 0; w < DESC_WORDS; w++) begin
                    wset_q[s][w] <= '0;
                end
            end
            for (int w = 0; w < DESC_WORDS; w++) begin
                rset_q[w] <= '0;
            end
        end else if (desc_we) begin
            for (int w = 0; w < DESC_WORDS; w++) begin
                if (desc_word == 2'(w)) begin
                    if (desc_dir == DIR_RD) begin
                        rset_q[w] <= desc_data;
                    end else begin
                        for (int s = 0; s < MAX_DESC; s++) begin
                            if (desc_slot == SLOT_W'(s)) wset_q[s][w] <= desc_data;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_STAT:  reg_rdata = {27'd0, err_lnk_q, err_wr_q, err_rd_q, busy_wr, busy_rd};
            OFS_RDPTR: reg_rdata = rd_ptr_q;
            OFS_WRPTR: reg_rdata = wr_ptr_q;
            OFS_EN:    reg_rdata = {30'd0, en_q};
            default: begin
                for (int s = 0; s < MAX_DESC; s++) begin
                    for (int w = 0; w < DESC_WORDS; w++) begin
                        if (reg_addr == OFS_WSET + 8'(12 * s + 4 * w)) reg_rdata = wset_q[s][w];
                    end
                end
                for (int w = 0; w < DESC_WORDS; w++) begin
                    if (reg_addr == OFS_RSET + 8'(4 * w)) reg_rdata = rset_q[w];
                end
            end
        endcase
    end

    // R11
    w1c_lnk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_hit && reg_wdata[4] && !err_set) |=> !err_lnk_q);

    // R8
    err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> (err_lnk_q && (($past(err_dir) == DIR_RD) ? err_rd_q : err_wr_q)));

endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
    import lldma_pkg::*;
#(
    parameter int MAX_DESC = 8,
    parameter int ADDR_W   = 32,
    localparam int SLOT_W  = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              abort_cmd,
    input  logic [31:0]       rd_list_ptr,
    input  logic [31:0]       wr_list_ptr,
    output logic              hst_req,
    output logic              hst_we,
    output logic [ADDR_W-1:0] hst_addr,
    output logic [31:0]       hst_wdata,
    input  logic              hst_ack,
    input  logic [31:0]       hst_rdata,
    output logic              loc_req,
    output logic              loc_we,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [31:0]       loc_wdata,
    input  logic              loc_ack,
    input  logic [31:0]       loc_rdata,
    output logic              busy_rd,
    output logic              busy_wr,
    output logic              done_rd,
    output logic              done_wr,
    output logic              err_set,
    output dma_dir_t          err_dir,
    output logic              desc_we,
    output dma_dir_t          desc_dir,
    output logic [SLOT_W-1:0] desc_slot,
    output logic [1:0]        desc_word,
    output logic [31:0]       desc_data
);

    walk_state_t       state_q, state_d;
    dma_dir_t          dir_q;
    logic [ADDR_W-1:0] fptr_q, src_q, dst_q;
    logic [1:0]        widx_q;
    logic [SLOT_W-1:0] dcount_q;
    logic [31:0]       dw0_q, dw1_q, dlen_q, xdata_q;
    logic [30:0]       rem_q;
    logic              abort_pend_q, done_rd_q, done_wr_q;

    logic        abort_now, src_ack, dst_ack, desc_bad, last_word;
    logic [31:0] src_rdata;

    always_comb begin
        abort_now = abort_pend_q | abort_cmd;
        src_ack   = (dir_q == DIR_RD) ? hst_ack : loc_ack;
        dst_ack   = (dir_q == DIR_RD) ? loc_ack : hst_ack;
        src_rdata = (dir_q == DIR_RD) ? hst_rdata : loc_rdata;
        desc_bad  = (dlen_q[30:0] == 31'd0) || (dlen_q[1:0] != 2'b00) ||
                    (!dlen_q[31] && (dcount_q == SLOT_W'(MAX_DESC - 1)));
        last_word = (rem_q == 31'd4);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_rd || start_wr) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (hst_ack) begin
                    if (abort_now)           state_d = ST_IDLE;
                    else if (widx_q == 2'd2) state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (abort_now || desc_bad) state_d = ST_IDLE;
                else                       state_d = ST_MOVE_RD;
            end
            ST_MOVE_RD: begin
                if (src_ack) state_d = ST_MOVE_WR;
            end
            ST_MOVE_WR: begin
                if (dst_ack) begin
                    if (abort_now)      state_d = ST_IDLE;
                    else if (!last_word) state_d = ST_MOVE_RD;
                    else if (dlen_q[31]) state_d = ST_IDLE;
                    else                 state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q        <= DIR_RD;
            fptr_q       <= '0;
            src_q        <= '0;
            dst_q        <= '0;
            widx_q       <= '0;
            dcount_q     <= '0;
            dw0_q        <= '0;
            dw1_q        <= '0;
            dlen_q       <= '0;
            xdata_q      <= '0;
            rem_q        <= '0;
            abort_pend_q <= 1'b0;
            done_rd_q    <= 1'b0;
            done_wr_q    <= 1'b0;
        end else begin
            done_rd_q <= 1'b0;
            done_wr_q <= 1'b0;
            if (state_d == ST_IDLE)                      abort_pend_q <= 1'b0;
            else if (abort_cmd && state_q != ST_IDLE)    abort_pend_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_rd || start_wr) begin
                        dir_q    <= start_wr ? DIR_WR : DIR_RD;
                        fptr_q   <= start_wr ? wr_list_ptr[ADDR_W-1:0] : rd_list_ptr[ADDR_W-1:0];
                        widx_q   <= '0;
                        dcount_q <= '0;
                    end
                end
                ST_FETCH: begin
                    if (hst_ack) begin
                        fptr_q <= fptr_q + ADDR_W'(4);
                        widx_q <= widx_q + 2'd1;
                        unique case (widx_q)
                            2'd0:    dw0_q  <= hst_rdata;
                            2'd1:    dw1_q  <= hst_rdata;
                            default: dlen_q <= hst_rdata;
                        endcase
                    end
                end
                ST_CHECK: begin
                    src_q <= dw0_q[ADDR_W-1:0];
                    dst_q <= dw1_q[ADDR_W-1:0];
                    rem_q <= dlen_q[30:0];
                end
                ST_MOVE_RD: begin
                    if (src_ack) xdata_q <= src_rdata;
                end
                ST_MOVE_WR: begin
                    if (dst_ack) begin
                        src_q <= src_q + ADDR_W'(4);
                        dst_q <= dst_q + ADDR_W'(4);
                        rem_q <= rem_q - 31'd4;
                        if (state_d == ST_FETCH) begin
                            dcount_q <= dcount_q + SLOT_W'(1);
                            widx_q   <= '0;
                        end
                        if (!abort_now && last_word && dlen_q[31]) begin
                            done_rd_q <= (dir_q == DIR_RD);
                            done_wr_q <= (dir_q == DIR_WR);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        hst_req   = 1'b0;
        hst_we    = 1'b0;
        hst_addr  = dst_q;
        loc_req   = 1'b0;
        loc_we    = 1'b0;
        loc_addr  = dst_q;
        unique case (state_q)
            ST_FETCH: begin
                hst_req  = 1'b1;
                hst_addr = fptr_q;
            end
            ST_MOVE_RD: begin
                hst_req  = (dir_q == DIR_RD);
                loc_req  = (dir_q == DIR_WR);
                hst_addr = src_q;
                loc_addr = src_q;
            end
            ST_MOVE_WR: begin
                hst_req = (dir_q == DIR_WR);
                loc_req = (dir_q == DIR_RD);
                hst_we  = 1'b1;
                loc_we  = 1'b1;
            end
            default: ;
        endcase
        hst_wdata = xdata_q;
        loc_wdata = xdata_q;
        busy_rd   = (state_q != ST_IDLE) && (dir_q == DIR_RD);
        busy_wr   = (state_q != ST_IDLE) && (dir_q == DIR_WR);
        done_rd   = done_rd_q;
        done_wr   = done_wr_q;
        err_set   = (state_q == ST_CHECK) && !abort_now && desc_bad;
        err_dir   = dir_q;
        desc_we   = (state_q == ST_FETCH) && hst_ack;
        desc_dir  = dir_q;
        desc_slot = dcount_q;
        desc_word = widx_q;
        desc_data = hst_rdata;
    end

    // R12
    hst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_ack) |=> (hst_req && $stable(hst_addr) && $stable(hst_we) && $stable(hst_wdata)));

    // R12
    loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !loc_ack) |=> (loc_req && $stable(loc_addr) && $stable(loc_we) && $stable(loc_wdata)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd_q || done_wr_q) |=> !(done_rd_q || done_wr_q));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd_q || done_wr_q) |-> (!busy_rd && !busy_wr));

    // R2
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_wr) |=> busy_wr);

    // R10
    abort_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MOVE_WR && dst_ack && abort_now) |=> (!busy_rd && !busy_wr && !done_rd_q && !done_wr_q));

endmodule

// File: rtl/ll_dma_engine.sv
module ll_dma_engine
    import lldma_pkg::*;
#(
    parameter int MAX_DESC = 8,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              hst_req,
    output logic              hst_we,
    output logic [ADDR_W-1:0] hst_addr,
    output logic [31:0]       hst_wdata,
    input  logic              hst_ack,
    input  logic [31:0]       hst_rdata,
    output logic              loc_req,
    output logic              loc_we,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [31:0]       loc_wdata,
    input  logic              loc_ack,
    input  logic [31:0]       loc_rdata,
    output logic              rd_done,
    output logic              wr_done
);

    localparam int SLOT_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;

    logic              start_rd, start_wr, abort_cmd;
    logic [31:0]       rd_list_ptr, wr_list_ptr;
    logic              busy_rd, busy_wr, err_set, desc_we;
    dma_dir_t          err_dir, desc_dir;
    logic [SLOT_W-1:0] desc_slot;
    logic [1:0]        desc_word;
    logic [31:0]       desc_data;

    lldma_csr #(
        .MAX_DESC (MAX_DESC)
    ) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy_rd     (busy_rd),
        .busy_wr     (busy_wr),
        .err_set     (err_set),
        .err_dir     (err_dir),
        .desc_we     (desc_we),
        .desc_dir    (desc_dir),
        .desc_slot   (desc_slot),
        .desc_word   (desc_word),
        .desc_data   (desc_data),
        .start_rd    (start_rd),
        .start_wr    (start_wr),
        .abort_cmd   (abort_cmd),
        .rd_list_ptr (rd_list_ptr),
        .wr_list_ptr (wr_list_ptr)
    );

    lldma_walker #(
        .MAX_DESC (MAX_DESC),
        .ADDR_W   (ADDR_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_rd    (start_rd),
        .start_wr    (start_wr),
        .abort_cmd   (abort_cmd),
        .rd_list_ptr (rd_list_ptr),
        .wr_list_ptr (wr_list_ptr),
        .hst_req     (hst_req),
        .hst_we      (hst_we),
        .hst_addr    (hst_addr),
        .hst_wdata   (hst_wdata),
        .hst_ack     (hst_ack),
        .hst_rdata   (hst_rdata),
        .loc_req     (loc_req),
        .loc_we      (loc_we),
        .loc_addr    (loc_addr),
        .loc_wdata   (loc_wdata),
        .loc_ack     (loc_ack),
        .loc_rdata   (loc_rdata),
        .busy_rd     (busy_rd),
        .busy_wr     (busy_wr),
        .done_rd     (rd_done),
        .done_wr     (wr_done),
        .err_set     (err_set),
        .err_dir     (err_dir),
        .desc_we     (desc_we),
        .desc_dir    (desc_dir),
        .desc_slot   (desc_slot),
        .desc_word   (desc_word),
        .desc_data   (desc_data)
    );

endmodule

// File: tb/tb_ll_dma_engine.sv
`timescale 1ns/1ps
module tb_ll_dma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h04;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hst_req, hst_we, loc_req, loc_we, rd_done, wr_done;
    logic [31:0] hst_addr, hst_wdata, loc_addr, loc_wdata;
    logic        hst_ack = 1'b0, loc_ack = 1'b0;
    logic [31:0] hst_rdata = '0, loc_rdata = '0;

    logic [31:0] hmem [1024];
    logic [31:0] lmem [1024];

    int n_chk = 0, n_fail = 0;
    int h_lat = 0, l_lat = 0;
    int n_hwr = 0, n_lrd = 0, n_hack = 0, n_lwr = 0;
    int n_done_rd = 0, n_done_wr = 0;
    int hs_viol = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ll_dma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_ack(loc_ack), .loc_rdata(loc_rdata),
        .rd_done(rd_done), .wr_done(wr_done)
    );

    // host memory model: acknowledges at falling edges after h_lat wait cycles
    logic        h_busy = 1'b0;
    logic [31:0] h_seen;
    int          h_cnt = 0;
    always @(negedge clk) begin
        if (hst_ack) begin
            hst_ack = 1'b0;
        end else if (hst_req) begin
            if (h_busy && hst_addr !== h_seen) hs_viol++;
            if (!h_busy) begin h_busy = 1'b1; h_seen = hst_addr; h_cnt = h_lat; end
            if (h_cnt == 0) begin
                hst_ack = 1'b1;
                h_busy  = 1'b0;
                n_hack++;
                if (hst_we) begin hmem[hst_addr[11:2]] = hst_wdata; n_hwr++; end
                else hst_rdata = hmem[hst_addr[11:2]];
            end else h_cnt--;
        end
    end

    logic        l_busy = 1'b0;
    logic [31:0] l_seen;
    int          l_cnt = 0;
    always @(negedge clk) begin
        if (loc_ack) begin
            loc_ack = 1'b0;
        end else if (loc_req) begin
            if (l_busy && loc_addr !== l_seen) hs_viol++;
            if (!l_busy) begin l_busy = 1'b1; l_seen = loc_addr; l_cnt = l_lat; end
            if (l_cnt == 0) begin
                loc_ack = 1'b1;
                l_busy  = 1'b0;
                if (loc_we) begin lmem[loc_addr[11:2]] = loc_wdata; n_lwr++; end
                else begin loc_rdata = lmem[loc_addr[11:2]]; n_lrd++; end
            end else l_cnt--;
        end
    end

    always @(negedge clk) begin
        if (rst_n && rd_done) n_done_rd++;
        if (rst_n && wr_done) n_done_wr++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hput(input logic [31:0] a, input logic [31:0] d);
        hmem[a[11:2]] = d;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 8'h04;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 8'h04;
    endtask

    // polls status at falling edges; reports the done strobe in the first idle sample
    task automatic wait_idle(output logic seen_done);
        logic [31:0] st;
        seen_done = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            reg_read(8'h04, st);
            if (st[1:0] == 2'b00) begin
                seen_done = rd_done | wr_done;
                break;
            end
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(8'h04, v); check("R1 status after reset", v, 32'h0);
        reg_read(8'h08, v); check("R1 read pointer after reset", v, 32'h0);
        reg_read(8'h0C, v); check("R1 write pointer after reset", v, 32'h0);
        reg_read(8'h10, v); check("R1 enable after reset", v, 32'h0);
        check("R1 no request after reset", {30'd0, hst_req, loc_req}, 32'h0);
        check("R1 done low after reset", {30'd0, rd_done, wr_done}, 32'h0);
    endtask

    task automatic t_write_single;
        logic [31:0] v;
        logic dn;
        int d0;
        for (int i = 0; i < 4; i++) lmem[32'h40 + i] = 32'hA000_0000 + i;
        hput(32'h000, 32'h100); hput(32'h004, 32'h200); hput(32'h008, 32'h8000_0010);
        reg_write(8'h10, 32'h3);
        reg_write(8'h0C, 32'h000);
        d0 = n_done_wr;
        reg_read(8'h04, v); check("R2 idle before start", v & 32'h3, 32'h0);
        reg_write(8'h00, 32'h2);
        reg_read(8'h04, v); check("R2 write busy the cycle after start", v & 32'h3, 32'h2);
        wait_idle(dn);
        check("R7 done strobe with busy clear", {31'd0, dn}, 32'h1);
        @(negedge clk);
        check("R7 single done strobe", n_done_wr - d0, 32'd1);
        for (int i = 0; i < 4; i++) check("R5 local to host word", hmem[32'h80 + i], 32'hA000_0000 + i);
        check("R5 no word past length", hmem[32'h84], 32'h0);
        reg_read(8'h80, v); check("R6 set0 local", v, 32'h100);
        reg_read(8'h84, v); check("R6 set0 host", v, 32'h200);
        reg_read(8'h88, v); check("R6 set0 length", v, 32'h8000_0010);
    endtask

    task automatic t_read_chain;
        logic [31:0] v;
        logic dn;
        int d0;
        h_lat = 2;
        hput(32'h300, 32'hB000_0000); hput(32'h304, 32'hB000_0001);
        hput(32'h320, 32'hC000_0000);
        hput(32'h340, 32'hD000_0000); hput(32'h344, 32'hD000_0001); hput(32'h348, 32'hD000_0002);
        hput(32'h040, 32'h300); hput(32'h044, 32'h400); hput(32'h048, 32'h8);
        hput(32'h04C, 32'h320); hput(32'h050, 32'h500); hput(32'h054, 32'h4);
        hput(32'h058, 32'h340); hput(32'h05C, 32'h600); hput(32'h060, 32'h8000_000C);
        reg_write(8'h08, 32'h040);
        d0 = n_done_rd;
        reg_write(8'h00, 32'h1);
        reg_read(8'h04, v); check("R2 read busy the cycle after start", v & 32'h3, 32'h1);
        wait_idle(dn);
        check("R7 read done with busy clear", {31'd0, dn}, 32'h1);
        @(negedge clk);
        check("R7 one read done for the chain", n_done_rd - d0, 32'd1);
        check("R4 desc0 word0", lmem[32'h100], 32'hB000_0000);
        check("R4 desc0 word1", lmem[32'h101], 32'hB000_0001);
        check("R4 desc1 word", lmem[32'h140], 32'hC000_0000);
        for (int i = 0; i < 3; i++) check("R5 host to local word", lmem[32'h180 + i], 32'hD000_0000 + i);
        reg_read(8'hE0, v); check("R6 read set host", v, 32'h340);
        reg_read(8'hE4, v); check("R6 read set local", v, 32'h600);
        reg_read(8'hE8, v); check("R6 read set length", v, 32'h8000_000C);
        h_lat = 0;
    endtask

    task automatic t_ignored_starts;
        logic [31:0] v;
        int a0;
        reg_write(8'h10, 32'h2);
        a0 = n_hack;
        reg_write(8'h00, 32'h1);
        reg_read(8'h04, v); check("R3 read start while read disabled", v & 32'h3, 32'h0);
        reg_write(8'h10, 32'h1);
        reg_write(8'h00, 32'h2);
        reg_read(8'h04, v); check("R3 write start while write disabled", v & 32'h3, 32'h0);
        reg_write(8'h10, 32'h3);
        reg_write(8'h00, 32'h3);
        reg_read(8'h04, v); check("R2 unknown command code ignored", v & 32'h3, 32'h0);
        repeat (10) @(negedge clk);
        check("R3 no memory traffic from ignored starts", n_hack - a0, 32'd0);
    endtask

    task automatic t_len_error;
        logic [31:0] v;
        logic dn;
        int d0;
        hput(32'h080, 32'h100); hput(32'h084, 32'h280); hput(32'h088, 32'h8000_0006);
        reg_write(8'h0C, 32'h080);
        d0 = n_done_wr;
        reg_write(8'h00, 32'h2);
        wait_idle(dn);
        reg_read(8'h04, v); check("R8 link and write error bits", v, 32'h18);
        check("R8 no done on error", {31'd0, dn}, 32'h0);
        check("R8 no word moved", hmem[32'hA0], 32'h0);
        check("R8 no done count", n_done_wr - d0, 32'd0);
    endtask

    task automatic t_cancel;
        logic [31:0] v;
        logic dn;
        int w0, r0, d0;
        h_lat = 1; l_lat = 1;
        for (int i = 0; i < 64; i++) lmem[i] = 32'hE000_0000 + i;
        hput(32'h0C0, 32'h000); hput(32'h0C4, 32'h800); hput(32'h0C8, 32'h8000_0100);
        reg_write(8'h0C, 32'h0C0);
        w0 = n_hwr; r0 = n_lrd; d0 = n_done_wr;
        reg_write(8'h00, 32'h2);
        repeat (30) @(negedge clk);
        reg_write(8'h00, 32'h0);
        wait_idle(dn);
        reg_read(8'h04, v); check("R10 cancel clears busy keeps errors", v, 32'h18);
        check("R10 no done after cancel", {31'd0, dn}, 32'h0);
        check("R10 partial transfer", ((n_hwr - w0) > 0 && (n_hwr - w0) < 64) ? 32'h1 : 32'h0, 32'h1);
        check("R10 every word read was written", n_hwr - w0, n_lrd - r0);
        check("R10 no done count", n_done_wr - d0, 32'd0);
        h_lat = 0; l_lat = 0;
    endtask

    task automatic t_long_chain;
        logic [31:0] v;
        logic dn;
        for (int k = 0; k < 8; k++) begin
            lmem[32'h40 + k] = 32'hF000_0000 + k;
            hput(32'h100 + 12 * k, 32'h100 + 4 * k);
            hput(32'h104 + 12 * k, 32'hA00 + 4 * k);
            hput(32'h108 + 12 * k, 32'h4);
        end
        reg_write(8'h0C, 32'h100);
        reg_write(8'h04, 32'h18);
        reg_write(8'h00, 32'h2);
        wait_idle(dn);
        reg_read(8'h04, v); check("R9 unterminated chain error", v, 32'h18);
        for (int k = 0; k < 7; k++) check("R9 first seven moved", hmem[32'h280 + k], 32'hF000_0000 + k);
        check("R9 eighth not moved", hmem[32'h287], 32'h0);
        reg_read(8'hD4, v); check("R6 set7 local", v, 32'h11C);
        reg_read(8'hD8, v); check("R6 set7 host", v, 32'hA1C);
        reg_read(8'hDC, v); check("R6 set7 length", v, 32'h4);
    endtask

    task automatic t_stop_and_busy_start;
        logic [31:0] v;
        logic dn;
        int d0;
        h_lat = 1; l_lat = 1;
        hput(32'h180, 32'hC00); hput(32'h184, 32'h800); hput(32'h188, 32'h8000_0100);
        reg_write(8'h08, 32'h180);
        d0 = n_done_rd;
        reg_write(8'h00, 32'h1);
        repeat (10) @(negedge clk);
        reg_write(8'h00, 32'h2);
        reg_read(8'h04, v); check("R3 write start while read busy ignored", v & 32'h3, 32'h1);
        reg_write(8'h00, 32'h4);
        wait_idle(dn);
        reg_read(8'h04, v); check("R10 stop clears busy keeps errors", v, 32'h18);
        check("R10 no done after stop", n_done_rd - d0, 32'd0);
        h_lat = 0; l_lat = 0;
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        reg_write(8'h04, 32'h0);
        reg_read(8'h04, v); check("R11 writing zero keeps errors", v, 32'h18);
        reg_write(8'h04, 32'h8);
        reg_read(8'h04, v); check("R11 clear write error", v, 32'h10);
        reg_write(8'h04, 32'h10);
        reg_read(8'h04, v); check("R11 clear link error", v, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin hmem[i] = '0; lmem[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_single();
        t_read_chain();
        t_ignored_starts();
        t_len_error();
        t_cancel();
        t_long_chain();
        t_stop_and_busy_start();
        t_w1c();
        check("R12 request held stable until acknowledged", hs_viol, 32'd0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..R12 run actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule